// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor reach the management registers of an external Ethernet PHY. The host sees two word-wide registers on a simple synchronous bus. One is a command register that holds the PHY address, the PHY register number, a direction bit and a busy flag. The other is a data register. Any write to the command register while the block is idle starts one clause-22 management frame on the MDC/MDIO pins. The frame is a read or a write, as the direction bit selects. The busy flag stays set until the last MDC cycle of the frame has ended, and then it clears by itself.

For a write, software loads the 16-bit payload into the data register first and then writes the command register. The block takes a copy of the payload when the frame starts. For a read, the 16 bits that the PHY returns are placed in the data register when busy clears. MDC comes from the system clock through an even divider and stays low between frames. The block changes MDIO while MDC is low and samples read data on the rising edge of MDC. MDIO is driven through an output-enable pin, so that a pad-level tri-state buffer can be built from it.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy flag and the data register read as 0, the MDIO output enable is 0 and MDC is low.
- R2: The command register reads back the PHY address in bits 15:11, the register number in bits 10:6, the direction in bit 1 (1 = write, 0 = read) and busy in bit 0. All other bits read as 0.
- R3: A command write while idle sets busy in the next cycle. Busy stays 1 for exactly 64 MDC cycles of frame and then returns to 0 on its own. MDIO is never driven while busy is 0.
- R4: Every frame starts with 32 ones, then start bits 0,1, then the opcode (1,0 for read; 0,1 for write), then the 5-bit PHY address MSB first, then the 5-bit register number MSB first.
- R5: A write frame continues with turnaround bits 1,0 and then the 16 data bits MSB first. The data is the value the data register held when the frame started.
- R6: On a read frame MDIO is released for the two turnaround bits and the 16 data bits. The 16 bits sampled on MDC rising edges, MSB first, appear in data register bits 15:0 once busy is 0.
- R7: MDC idles low. While a frame runs, MDC has a period of MDC_DIV system clocks with equal high and low halves. MDIO and its enable change only while MDC is low.
- R8: A command write of all zeros still runs a complete read frame to PHY 0, register 0, with 64 MDC cycles.
- R9: A command-register write while busy is 1 is ignored. The in-flight frame goes out unchanged, and the command register read back keeps its fields.
- R10: The data register reads back its 16 bits in bits 15:0, with bits 31:16 as 0. Bus read data is valid in the cycle after the read strobe (register select 0 = command, 1 = data).

Parameters: `MDC_DIV` (even, at least 2, default 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle bus write strobe |
| rd_en_i | input | 1 | One-cycle bus read strobe |
| sel_i | input | 1 | Register select: 0 command, 1 data |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, registered |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO pin value as seen at the pad |

## Verification
The assertions assume that the bus never asserts the read and write strobes in the same cycle, and that MDIO input is only meaningful while the block has released the line. The bench strobes one access at a time through its tasks. Its PHY model drives the input only during the data bits of a read and otherwise holds it high, like a pull-up. Random operations wait for busy to clear before they issue the next command. Writes made while busy are issued on purpose, to show that they are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_IDX     = 46;  // first turnaround bit
  localparam int unsigned DATA_IDX   = 48;  // first data bit
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] ST_BITS = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef enum logic {
    SEL_CMD  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic       wr;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned MDC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_tick_o,
  output logic fall_tick_o
);
  localparam int unsigned HALF  = MDC_DIV / 2;
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick        = en_i && (cnt_q == CNT_LAST);
  assign rise_tick_o = tick && !mdc_q;
  assign fall_tick_o = tick && mdc_q;
  assign mdc_o       = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic [15:0] wdata_i,
  input  logic        mdc_i,
  input  logic        rise_tick_i,
  input  logic        fall_tick_i,
  input  logic        mdio_i,
  output logic        run_o,
  output logic        done_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rdata_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_IDX);

  logic                  run_q;
  logic                  wr_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sr_q;
  logic [15:0]           cap_q;
  logic [FRAME_BITS-1:0] frame_init;

  always_comb begin
    frame_init = {{32{1'b1}}, ST_BITS,
                  cmd_i.wr ? OP_WR : OP_RD,
                  cmd_i.phy, cmd_i.regn,
                  cmd_i.wr ? TA_WR : 2'b00,
                  cmd_i.wr ? wdata_i : 16'h0000};
  end

  assign run_o     = run_q;
  assign done_o    = run_q && fall_tick_i && (idx_q == IDX_LAST);
  assign mdio_o    = sr_q[FRAME_BITS-1];
  assign mdio_oe_o = run_q && (wr_q || (idx_q < IDX_TA));
  assign rdata_o   = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      wr_q  <= 1'b0;
      idx_q <= '0;
      sr_q  <= '1;
      cap_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q <= 1'b1;
        wr_q  <= cmd_i.wr;
        idx_q <= '0;
        sr_q  <= frame_init;
      end
    end else begin
      if (rise_tick_i && !wr_q && (idx_q >= IDX_DATA))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_tick_i) begin
        sr_q <= {sr_q[FRAME_BITS-2:0], 1'b1};
        if (idx_q == IDX_LAST) run_q <= 1'b0;
        else                   idx_q <= idx_q + 1'b1;
      end
    end
  end

  // MDC must be low whenever no frame is in progress
  p_mdc_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !mdc_i);

  // MDIO and its enable hold still while MDC stays high
  p_mdio_steady_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic        sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        done_i,
  input  logic [15:0] rd_word_i,
  output logic        start_o,
  output mdio_cmd_t   cmd_o,
  output logic [15:0] wdata_o,
  output logic        busy_o
);
  mdio_cmd_t   cmd_q;
  logic        busy_q;
  logic [15:0] data_q;
  logic [31:0] rdata_q;
  logic        cmd_wr;
  logic        data_wr;
  logic        unused_bits;

  assign cmd_wr  = wr_en_i && (reg_sel_e'(sel_i) == SEL_CMD);
  assign data_wr = wr_en_i && (reg_sel_e'(sel_i) == SEL_DATA);
  assign start_o = cmd_wr && !busy_q;
  assign cmd_o   = '{phy: wdata_i[15:11], regn: wdata_i[10:6], wr: wdata_i[1]};
  assign wdata_o = data_q;
  assign busy_o  = busy_q;
  assign rdata_o = rdata_q;
  assign unused_bits = ^{wdata_i[31:16], wdata_i[5:2], wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (start_o) begin
        cmd_q  <= cmd_o;
        busy_q <= 1'b1;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
      if (done_i && !cmd_q.wr) data_q <= rd_word_i;
      else if (data_wr)        data_q <= wdata_i[15:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      if (reg_sel_e'(sel_i) == SEL_CMD)
        rdata_q <= {16'h0000, cmd_q.phy, cmd_q.regn, 4'b0000, cmd_q.wr, busy_q};
      else
        rdata_q <= {16'h0000, data_q};
    end
  end

  // busy only drops on frame completion
  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> busy_q);

  // command fields frozen while a frame is in flight
  p_cmd_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> $stable(cmd_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned MDC_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic        sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        start;
  mdio_cmd_t   cmd;
  logic [15:0] tx_word;
  logic [15:0] rx_word;
  logic        busy;
  logic        run;
  logic        done;
  logic        rise_tick;
  logic        fall_tick;
  logic        mdc;

  mdio_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .sel_i     (sel_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .done_i    (done),
    .rd_word_i (rx_word),
    .start_o   (start),
    .cmd_o     (cmd),
    .wdata_o   (tx_word),
    .busy_o    (busy)
  );

  mdio_clkgen #(.MDC_DIV(MDC_DIV)) u_clkgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (run),
    .mdc_o       (mdc),
    .rise_tick_o (rise_tick),
    .fall_tick_o (fall_tick)
  );

  mdio_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_i       (cmd),
    .wdata_i     (tx_word),
    .mdc_i       (mdc),
    .rise_tick_i (rise_tick),
    .fall_tick_i (fall_tick),
    .mdio_i      (mdio_i),
    .run_o       (run),
    .done_o      (done),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o),
    .rdata_o     (rx_word)
  );

  assign mdc_o = mdc;

  // the line is only driven inside a busy window
  p_oe_needs_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  mdio_master #(.MDC_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = !clk;

  // PHY model
  int          rcount = 0;
  logic [63:0] cap_val, cap_oe;
  logic [15:0] phy_val = '0;

  always @(posedge mdc) begin
    if (rcount < 64) begin
      cap_val[63-rcount] = mdio_o;
      cap_oe[63-rcount]  = mdio_oe;
    end
    rcount = rcount + 1;
  end

  always @(negedge mdc) begin
    if (rcount >= 48 && rcount < 64) mdio_i = phy_val[63-rcount];
    else                             mdio_i = 1'b1;
  end

  // MDC shape monitor (R7)
  int   hi_change = 0;
  int   bad_period = 0;
  int   since_rise = 0;
  logic p_mdc = 1'b0, p_o = 1'b0, p_oe = 1'b0;
  always @(negedge clk) begin
    if (mdc && p_mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) hi_change++;
    if (mdc && !p_mdc) begin
      if (since_rise != 0 && since_rise != DIV && since_rise < 3 * DIV) bad_period++;
      since_rise = 1;
    end else if (since_rise != 0) begin
      since_rise++;
    end
    if (!mdc && !uut.mdio_oe_o && since_rise > DIV) since_rise = 0;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic s, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [63:0] exp_frame(input logic [4:0] phy, input logic [4:0] rg,
                                            input logic wr, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
            wr ? 2'b10 : 2'b00, wr ? d : 16'h0000};
  endfunction

  function automatic logic [63:0] exp_oe(input logic wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic wait_idle(output int polls);
    logic [31:0] r;
    polls = 0;
    do begin
      bus_rd(1'b0, r);
      polls++;
    end while (r[0] && polls < 2000);
  endtask

  // Full operation; optional intrusive write while busy
  task automatic run_op(input logic [4:0] phy, input logic [4:0] rg, input logic wr,
                        input logic [15:0] d, input logic [15:0] pv, input logic intrude);
    logic [31:0] r;
    int polls;
    phy_val = pv;
    rcount  = 0;
    mdio_i  = 1'b1;
    if (wr) bus_wr(1'b1, {16'hDEAD, d});
    bus_wr(1'b0, {16'h0, phy, rg, 4'b0, wr, 1'b0});
    bus_rd(1'b0, r);
    check("R3 busy set", {63'h0, r[0]}, 64'h1);
    check("R2 cmd readback", {32'h0, r}, {48'h0, phy, rg, 4'b0, wr, 1'b1});
    if (intrude) begin
      repeat (20) @(negedge clk);
      bus_wr(1'b0, {16'h0, ~phy, ~rg, 4'b0, ~wr, 1'b1});
      if (wr) bus_wr(1'b1, {16'h0, ~d});
      bus_rd(1'b0, r);
      check("R9 cmd kept", {32'h0, r}, {48'h0, phy, rg, 4'b0, wr, 1'b1});
    end
    wait_idle(polls);
    check("R3 busy clears", {63'h0, polls >= 2000}, 64'h0);
    check("R3 mdc cycles", 64'(rcount), 64'd64);
    check(wr ? "R4 R5 write frame" : "R4 R6 read frame",
          cap_val & exp_oe(wr), exp_frame(phy, rg, wr, d) & exp_oe(wr));
    check(wr ? "R5 oe" : "R6 oe release", cap_oe, exp_oe(wr));
    if (!wr) begin
      bus_rd(1'b1, r);
      check("R6 R10 read data", {32'h0, r}, {48'h0, pv});
    end
    check("R3 idle release", {63'h0, mdio_oe}, 64'h0);
    check("R7 mdc idle", {63'h0, mdc}, 64'h0);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check("R1 mdc low in reset", {63'h0, mdc}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe released", {63'h0, mdio_oe}, 64'h0);
    check("R1 mdc low", {63'h0, mdc}, 64'h0);
    bus_rd(1'b0, r);
    check("R1 cmd reset", {32'h0, r}, 64'h0);
    bus_rd(1'b1, r);
    check("R1 data reset", {32'h0, r}, 64'h0);

    // R10 data register readback, upper bits zero
    bus_wr(1'b1, 32'hFFFF_A5C3);
    bus_rd(1'b1, r);
    check("R10 data readback", {32'h0, r}, 64'h0000_0000_0000_A5C3);

    // R2 undefined bits of command read 0; R8 all-zero-style launch
    phy_val = 16'h0000; rcount = 0;
    bus_wr(1'b0, 32'hFFFF_003C);
    bus_rd(1'b0, r);
    check("R2 undefined bits zero", {32'h0, r}, 64'h1);
    begin int p; wait_idle(p); end

    // R8 all-zero command
    run_op(5'd0, 5'd0, 1'b0, 16'h0, 16'h1234, 1'b0);

    // directed extremes
    run_op(5'h1F, 5'h1F, 1'b1, 16'hFFFF, 16'h0, 1'b0);
    run_op(5'h15, 5'h0A, 1'b1, 16'h8001, 16'h0, 1'b0);
    run_op(5'h0A, 5'h15, 1'b0, 16'h0, 16'hFFFF, 1'b0);
    run_op(5'h01, 5'h10, 1'b0, 16'h0, 16'h8001, 1'b0);

    // R9 intrusive writes while busy
    run_op(5'h03, 5'h07, 1'b1, 16'h5A5A, 16'h0, 1'b1);
    run_op(5'h1C, 5'h02, 1'b0, 16'h0, 16'hC3A5, 1'b1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      run_op(5'($urandom), 5'($urandom), 1'($urandom), 16'($urandom),
             16'($urandom), ($urandom % 4) == 0);
    end

    check("R7 mdio steady while mdc high", 64'(hi_change), 64'h0);
    check("R7 mdc period", 64'(bad_period), 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule